// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches the input pins of an eight-pin general-purpose I/O port and raises one combined interrupt line when a pin shows the event it was configured for. Each pin is set up independently: it is either edge triggered or level triggered, an edge-triggered pin may react to any change or to one chosen direction, and a polarity bit selects rising/falling for edges or high/low for levels. Pins the port drives as outputs never produce edge events.

Detected events land in a sticky raw status register that software reads and clears by writing ones. A mask register gates the raw status into a masked view, and the interrupt output is the OR of that masked view. The block sits on the same simple register bus as the rest of the port and takes already-synchronized pin levels plus the port's direction vector; edges are found by comparing each level with a registered copy from the previous cycle.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset the sense, both-edges, polarity, mask, raw status and masked status registers all read 0 and `irqOut` is low.
- R2: The four configuration registers are read/write, 8 bits wide, at byte offsets sense 0x404, both-edges 0x408, polarity 0x40C and mask 0x410; bit n of each configures pin n.
- R3: An input pin with sense bit 0 and both-edges bit 1 sets its raw status bit (offset 0x414) on every change of level, rising or falling.
- R4: An input pin with sense bit 0 and both-edges bit 0 sets its raw status bit only on a rising edge when its polarity bit is 1, and only on a falling edge when its polarity bit is 0.
- R5: A pin with sense bit 1 sets its raw status bit in every cycle its level equals its polarity bit (1 = high, 0 = low).
- R6: A pin whose direction bit is 1 (output) produces no edge events.
- R7: Raw status bits are sticky; writing the clear register at 0x41C clears the raw bits where the written value has a 1 and leaves bits where it has a 0.
- R8: The masked status at 0x418 reads raw status AND mask, and `irqOut` is high exactly when that value is nonzero.
- R9: When a detected event and a clear hit the same status bit in the same cycle, the bit stays set.
- R10: Reads of any other offset, and reads with `busSel` low, return 0; the raw and masked status offsets ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinLevel | input | 8 | Synchronized pin levels |
| pinDir | input | 8 | Port direction vector, 1 = output |
| busSel | input | 1 | Register access select |
| busWe | input | 1 | Write enable, 1 = write |
| busAddr | input | 12 | Byte offset of the register |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The two functions that can meet in one cycle are event detection and software clearing of the same status bit. The bench provokes this twice: once by toggling a both-edges pin in exactly the cycle a clear write for that bit commits, and once by clearing a level-triggered bit while its pin still sits at the active level. In both cases the raw status is read back afterwards and must still show the bit set, while a clear issued once the condition is gone must remove it.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int NPINS  = 8;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_SENSE  = 12'h404;
  localparam logic [ADDR_W-1:0] OFS_BOTH   = 12'h408;
  localparam logic [ADDR_W-1:0] OFS_POL    = 12'h40C;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 12'h410;
  localparam logic [ADDR_W-1:0] OFS_RAW    = 12'h414;
  localparam logic [ADDR_W-1:0] OFS_MASKED = 12'h418;
  localparam logic [ADDR_W-1:0] OFS_CLEAR  = 12'h41C;

  typedef enum logic [2:0] {
    RD_NONE, RD_SENSE, RD_BOTH, RD_POL, RD_MASK, RD_RAW, RD_MASKED
  } rdSel_e;

  typedef struct packed {
    logic   wrSense;
    logic   wrBoth;
    logic   wrPol;
    logic   wrMask;
    logic   wrClear;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strobe
);
  always_comb begin
    strobe = '0;
    strobe.rdSel = RD_NONE;
    if (busSel) begin
      case (busAddr)
        OFS_SENSE:  begin strobe.rdSel = RD_SENSE;  strobe.wrSense = busWe; end
        OFS_BOTH:   begin strobe.rdSel = RD_BOTH;   strobe.wrBoth  = busWe; end
        OFS_POL:    begin strobe.rdSel = RD_POL;    strobe.wrPol   = busWe; end
        OFS_MASK:   begin strobe.rdSel = RD_MASK;   strobe.wrMask  = busWe; end
        OFS_RAW:    strobe.rdSel = RD_RAW;
        OFS_MASKED: strobe.rdSel = RD_MASKED;
        OFS_CLEAR:  strobe.wrClear = busWe;
        default: ;
      endcase
    end
  end

  // R2, R10: at most one register is written per access, and never without busSel
  p_onewr_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrSense, strobe.wrBoth, strobe.wrPol, strobe.wrMask, strobe.wrClear}));
  p_nosel_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |-> (strobe.rdSel == RD_NONE && !strobe.wrClear));
endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int W = NPINS
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] pinLevel,
  input  logic [W-1:0] pinDir,
  input  strobe_t      strobe,
  input  logic [W-1:0] busWdata,
  output logic [W-1:0] busRdata,
  output logic         irqOut
);
  logic [W-1:0] senseQ, bothQ, polQ, maskQ, statusQ, prevLevelQ;
  logic [W-1:0] changed, matchPol, edgeHit, levelHit, hit, clrMask;

  assign changed  = (pinLevel ^ prevLevelQ) & ~pinDir;
  assign matchPol = ~(pinLevel ^ polQ);
  assign edgeHit  = changed & ~senseQ & (bothQ | matchPol);
  assign levelHit = senseQ & matchPol;
  assign hit      = edgeHit | levelHit;
  assign clrMask  = strobe.wrClear ? busWdata : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      senseQ <= '0; bothQ <= '0; polQ <= '0; maskQ <= '0;
      statusQ <= '0; prevLevelQ <= '0;
    end else begin
      prevLevelQ <= pinLevel;
      if (strobe.wrSense) senseQ <= busWdata;
      if (strobe.wrBoth)  bothQ  <= busWdata;
      if (strobe.wrPol)   polQ   <= busWdata;
      if (strobe.wrMask)  maskQ  <= busWdata;
      statusQ <= (statusQ & ~clrMask) | hit;
    end
  end

  always_comb begin
    case (strobe.rdSel)
      RD_SENSE:  busRdata = senseQ;
      RD_BOTH:   busRdata = bothQ;
      RD_POL:    busRdata = polQ;
      RD_MASK:   busRdata = maskQ;
      RD_RAW:    busRdata = statusQ;
      RD_MASKED: busRdata = statusQ & maskQ;
      default:   busRdata = '0;
    endcase
  end

  assign irqOut = |(statusQ & maskQ);

  // R7: without a clear write no status bit falls
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrClear |=> ((statusQ & $past(statusQ)) == $past(statusQ)));
  // R7: a cleared bit with no event that cycle is gone next cycle
  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrClear |=> (($past(busWdata) & ~$past(hit) & statusQ) == '0));
  // R5, R9: an active level always leaves its bit set
  p_level_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|levelHit) |=> (($past(levelHit) & ~statusQ) == '0));
  // R6: an edge-mode output pin never raises its bit
  p_outpin_r6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(pinDir & ~senseQ) & statusQ & ~$past(statusQ)) == '0));
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NPINS-1:0]  pinLevel,
  input  logic [NPINS-1:0]  pinDir,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [NPINS-1:0]  busWdata,
  output logic [NPINS-1:0]  busRdata,
  output logic              irqOut
);
  strobe_t strobe;

  gpio_irq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .strobe(strobe)
  );

  gpio_irq_datapath #(.W(NPINS)) u_dp (
    .clk(clk), .rstN(rstN), .pinLevel(pinLevel), .pinDir(pinDir),
    .strobe(strobe), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );
endmodule

// File: tb/sim_gpio_irq_unit.sv
module sim_gpio_irq_unit;
  logic        clk = 0;
  logic        rstN = 0;
  logic [7:0]  pinLevel = '0;
  logic [7:0]  pinDir = '0;
  logic        busSel = 0;
  logic        busWe = 0;
  logic [11:0] busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic        irqOut;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  gpio_irq_unit u0 (.*);

  always #5 clk = ~clk;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1; busWe = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWe = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    busSel = 1; busWe = 0; busAddr = a;
    #1 chk(busRdata, exp, req);
    busSel = 0;
  endtask

  task automatic pins(input logic [7:0] v);
    @(negedge clk);
    pinLevel = v;
    @(negedge clk);
  endtask

  task automatic cleanAll();
    wr(12'h404, 0); wr(12'h408, 0); wr(12'h40C, 0); wr(12'h410, 0);
    pinDir = 0;
    pins(0);
    wr(12'h41C, 8'hFF);
  endtask

  task automatic tReset();
    rd(12'h404, 0, "R1 sense"); rd(12'h408, 0, "R1 both"); rd(12'h40C, 0, "R1 pol");
    rd(12'h410, 0, "R1 mask"); rd(12'h414, 0, "R1 raw"); rd(12'h418, 0, "R1 masked");
    chk({7'b0, irqOut}, 0, "R1 irq");
  endtask

  task automatic tConfig();
    wr(12'h404, 8'hA5); wr(12'h408, 8'h3C); wr(12'h40C, 8'h96); wr(12'h410, 8'h71);
    rd(12'h404, 8'hA5, "R2 sense"); rd(12'h408, 8'h3C, "R2 both");
    rd(12'h40C, 8'h96, "R2 pol");   rd(12'h410, 8'h71, "R2 mask");
    rd(12'h420, 0, "R10 unmapped"); rd(12'h004, 0, "R10 low offset");
    @(negedge clk); busSel = 0; busAddr = 12'h404; #1 chk(busRdata, 0, "R10 no select");
    cleanAll();
    wr(12'h414, 8'hFF); wr(12'h418, 8'hFF);
    rd(12'h414, 0, "R10 raw write ignored");
  endtask

  task automatic tBoth();
    cleanAll();
    wr(12'h408, 8'h01);
    pins(8'h01); rd(12'h414, 8'h01, "R3 rise");
    wr(12'h41C, 8'h01); rd(12'h414, 0, "R7 clear");
    pins(8'h00); rd(12'h414, 8'h01, "R3 fall");
  endtask

  task automatic tSingle();
    cleanAll();
    wr(12'h40C, 8'h02);
    pins(8'h02); rd(12'h414, 8'h02, "R4 rising pol1");
    wr(12'h41C, 8'h02);
    pins(8'h00); rd(12'h414, 0, "R4 falling pol1 ignored");
    pins(8'h04); rd(12'h414, 0, "R4 rising pol0 ignored");
    pins(8'h00); rd(12'h414, 8'h04, "R4 falling pol0");
    pins(8'h02); rd(12'h414, 8'h06, "R7 sticky");
    wr(12'h41C, 8'h00); rd(12'h414, 8'h06, "R7 zero clear");
    wr(12'h41C, 8'h04); rd(12'h414, 8'h02, "R7 partial clear");
  endtask

  task automatic tOutPin();
    cleanAll();
    pinDir = 8'h08;
    wr(12'h408, 8'h08);
    pins(8'h08); pins(8'h00);
    rd(12'h414, 0, "R6 output pin");
  endtask

  task automatic tMask();
    cleanAll();
    pins(8'h02); pins(8'h00);
    rd(12'h414, 8'h02, "R8 raw");
    wr(12'h410, 8'h01);
    rd(12'h418, 0, "R8 masked off"); chk({7'b0, irqOut}, 0, "R8 irq off");
    wr(12'h410, 8'h02);
    rd(12'h418, 8'h02, "R8 masked on"); chk({7'b0, irqOut}, 1, "R8 irq on");
  endtask

  task automatic tLevel();
    cleanAll();
    wr(12'h40C, 8'h10); wr(12'h404, 8'h10);
    rd(12'h414, 0, "R5 inactive");
    pins(8'h10); rd(12'h414, 8'h10, "R5 high level");
    wr(12'h41C, 8'h10); rd(12'h414, 8'h10, "R9 clear during level");
    pins(8'h00); wr(12'h41C, 8'h10); rd(12'h414, 0, "R5 clear after level");
    wr(12'h404, 8'h30);
    rd(12'h414, 8'h20, "R5 low level");
  endtask

  task automatic tCollide();
    cleanAll();
    wr(12'h408, 8'h01);
    @(negedge clk);
    pinLevel = 8'h01; busSel = 1; busWe = 1; busAddr = 12'h41C; busWdata = 8'h01;
    @(negedge clk);
    busSel = 0; busWe = 0;
    rd(12'h414, 8'h01, "R9 edge with clear");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    tReset(); tConfig(); tBoth(); tSingle(); tOutPin(); tMask(); tLevel(); tCollide();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual hung expected done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule